// File: doc/BRIEF.md
# Level-Sensitive Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt requests and merges them into one processor interrupt line. Each request line has a private configuration word that holds a 7-bit routing code. A source reaches the interrupt line only when its routing code equals the enable code chosen at build time. Writing the all-zero code masks the source. The controller holds no latch of its own, so a source counts only while its level stays high.

Software reads one select word to dispatch an interrupt. That word carries a pending flag together with the number of the winning source, so no scan of the sources is needed. When several enabled sources are high, the lowest number wins. Access is over a simple valid/ready register bus with 32-bit data. The bus accepts a request every cycle and returns read data one cycle after the read is accepted.

Top module: `vic_top`

## Requirements
- R1: After reset every routing field reads 0x00, the interrupt output is low, and the select word reads 0x00000000.
- R2: A write to byte offset 4*n (n = 0..63) replaces routing field n with write-data bits 6:0. A read of that offset returns the field in bits 6:0, and bits 31:7 read as zero.
- R3: A source counts as enabled only when its routing field exactly equals the enable code (default 0x51). Any other value, including nonzero codes, leaves it masked.
- R4: Bit 6 of the select word (default offset 0x10C) is 1 exactly when at least one enabled source is high in the sampled inputs.
- R5: Bits 5:0 of the select word give the lowest-numbered enabled, high source. They read 0 when bit 6 is 0, and bits 31:7 are always zero.
- R6: Source inputs are registered once and the interrupt output is registered after the OR of enabled sources. The output rises two clocks after a source rises, and it falls one clock after the write that masks the last active source.
- R7: Sources are levels with no latching. When a source drops, the select word stops reporting it one clock later and the interrupt output falls two clocks later.
- R8: Writes to the select offset or to any offset outside 0x000..0x0FC change no routing field.
- R9: The request ready signal is always high. A read produces exactly one response cycle (response valid high), on the clock after the read is accepted. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Level interrupt requests, one per source |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A sweep enables one source at a time and raises only that source, for every source number. This shows that the number field decodes every position, and it checks the rise and fall timing of the interrupt output on each line. With all sources enabled, patterns that mix many high bits tell a correct lowest-number priority apart from a highest-number priority or an OR-only scheme. Writing near-miss codes such as 0x50, 0x7F and 0x01 separates an exact-match enable from a nonzero or single-bit enable. Writes to the select word and to unmapped offsets are followed by a full read-back to show that no field changed.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int SRC_N   = 64;
    localparam int FIELD_W = 7;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;

    typedef struct packed {
        logic [SRC_N-1:0][FIELD_W-1:0] field;
    } cfg_state_t;

    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    typedef struct packed {
        logic [SRC_N-1:0] src;
        logic             irq;
    } core_state_t;
endpackage

// File: rtl/vic_cfg_regs.sv
module vic_cfg_regs
    import vic_pkg::*;
#(
    parameter logic [FIELD_W-1:0] EN_CODE = 7'h51
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [FIELD_W-1:0]   wr_field_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [FIELD_W-1:0]   rd_field_o,
    output logic [SRC_N-1:0]     enabled_o
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.field[wr_idx_i] = wr_field_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_field_o = st_q.field[rd_idx_i];

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign enabled_o[g] = (st_q.field[g] == EN_CODE);

        // R2
        field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && (wr_idx_i == IDX_W'(g))) |=> (st_q.field[g] == $past(wr_field_i)));

        // R8
        field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && (wr_idx_i == IDX_W'(g))) |=> $stable(st_q.field[g]));
    end
endmodule

// File: rtl/vic_pick.sv
module vic_pick
    import vic_pkg::*;
(
    input  logic [SRC_N-1:0] vec_i,
    output logic             pend_o,
    output logic [IDX_W-1:0] num_o
);
    logic [SRC_N-1:0] low_mask;

    always_comb begin
        pend_o = 1'b0;
        num_o  = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                pend_o = 1'b1;
                num_o  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        low_mask = ({{(SRC_N-1){1'b0}}, 1'b1} << num_o) - 1'b1;
        if (pend_o) begin
            // R5
            pick_hit_chk: assert (vec_i[num_o]);
            // R5
            no_lower_chk: assert ((vec_i & low_mask) == '0);
        end else begin
            // R4
            idle_num_chk: assert ((num_o == '0) && (vec_i == '0));
        end
    end
endmodule

// File: rtl/vic_bus.sv
module vic_bus
    import vic_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_OFFSET = 12'h10C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    output logic                rsp_valid_o,
    output logic [DATA_W-1:0]   rsp_rdata_o,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_idx_o,
    output logic [FIELD_W-1:0]  wr_field_o,
    output logic [IDX_W-1:0]    rd_idx_o,
    input  logic [FIELD_W-1:0]  rd_field_i,
    input  logic                sel_pend_i,
    input  logic [IDX_W-1:0]    sel_num_i
);
    bus_state_t st_d, st_q;
    logic              cfg_hit, sel_hit;
    logic [DATA_W-1:0] rd_word;
    logic              unused_bits;

    assign cfg_hit = (req_addr_i[ADDR_W-1:IDX_W+2] == '0);
    assign sel_hit = (req_addr_i[ADDR_W-1:2] == SEL_OFFSET[ADDR_W-1:2]);
    assign unused_bits = ^{req_wdata_i[DATA_W-1:FIELD_W], req_addr_i[1:0]};

    assign wr_en_o    = req_valid_i && req_write_i && cfg_hit;
    assign wr_idx_o   = req_addr_i[IDX_W+1:2];
    assign wr_field_o = req_wdata_i[FIELD_W-1:0];
    assign rd_idx_o   = req_addr_i[IDX_W+1:2];

    always_comb begin
        rd_word = '0;
        if (cfg_hit) begin
            rd_word[FIELD_W-1:0] = rd_field_i;
        end else if (sel_hit) begin
            rd_word[IDX_W:0] = {sel_pend_i, sel_num_i};
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.rsp_valid = req_valid_i && !req_write_i;
        if (req_valid_i && !req_write_i) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_rdata_o = st_q.rdata;

    // R9
    rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && !req_write_i));

    // R9
    read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter logic [FIELD_W-1:0] ENABLE_CODE = 7'h51,
    parameter logic [ADDR_W-1:0]  SEL_OFFSET  = 12'h10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       src_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [11:0]       req_addr_i,
    input  logic [31:0]       req_wdata_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_rdata_o,
    output logic              irq_o
);
    core_state_t st_d, st_q;

    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [FIELD_W-1:0] wr_field;
    logic [IDX_W-1:0]   rd_idx;
    logic [FIELD_W-1:0] rd_field;
    logic [SRC_N-1:0]   enabled;
    logic [SRC_N-1:0]   active;
    logic               sel_pend;
    logic [IDX_W-1:0]   sel_num;

    assign req_ready_o = 1'b1;
    assign active      = st_q.src & enabled;

    always_comb begin
        st_d     = st_q;
        st_d.src = src_i;
        st_d.irq = |active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    vic_cfg_regs #(.EN_CODE(ENABLE_CODE)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_field_i (wr_field),
        .rd_idx_i   (rd_idx),
        .rd_field_o (rd_field),
        .enabled_o  (enabled)
    );

    vic_pick u_pick (
        .vec_i  (active),
        .pend_o (sel_pend),
        .num_o  (sel_num)
    );

    vic_bus #(.SEL_OFFSET(SEL_OFFSET)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_field_o  (wr_field),
        .rd_idx_o    (rd_idx),
        .rd_field_i  (rd_field),
        .sel_pend_i  (sel_pend),
        .sel_num_i   (sel_num)
    );

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pend |=> irq_o);

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_pend |=> !irq_o);
endmodule

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;
    localparam logic [11:0] SEL_A = 12'h10C;
    localparam logic [6:0]  ENC   = 7'h51;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vic_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        v = rsp_valid; d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic expect_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        bus_read(a, d, v);
        chk({req, " rsp_valid"}, {31'b0, v}, 32'd1);
        chk(req, d, exp);
    endtask

    function automatic logic [6:0] pat_of(input int i);
        return 7'((i * 37 + 5) % 128);
    endfunction

    function automatic logic [31:0] lowest_word(input logic [63:0] v);
        for (int i = 0; i < 64; i++) begin
            if (v[i]) return 32'h40 | 32'(i);
        end
        return 32'h0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        expect_read("R1 select", SEL_A, 32'h0);
        expect_read("R1 field0", 12'h000, 32'h0);
        expect_read("R1 field63", 12'h0FC, 32'h0);
        chk("R9 ready", {31'b0, req_ready}, 32'd1);

        // R2: write with upper garbage, read back
        for (int i = 0; i < 64; i++) begin
            bus_write(12'(i * 4), 32'hDEADBE80 | 32'(pat_of(i)));
        end
        chk("R9 no write response", {31'b0, rsp_valid}, 32'd0);
        for (int i = 0; i < 64; i++) begin
            expect_read("R2 readback", 12'(i * 4), 32'(pat_of(i)));
        end

        // R8: select and unmapped writes change nothing
        bus_write(SEL_A, 32'h7F);
        bus_write(12'h100, 32'h51);
        bus_write(12'h200, 32'h51);
        bus_write(12'hFFC, 32'h00);
        for (int i = 0; i < 64; i++) begin
            expect_read("R8 unchanged", 12'(i * 4), 32'(pat_of(i)));
        end

        for (int i = 0; i < 64; i++) bus_write(12'(i * 4), 32'h0);

        // R4 R5 R6: single-source sweep
        for (int i = 0; i < 64; i++) begin
            bus_write(12'(i * 4), 32'(ENC));
            src = 64'h1 << i;
            @(negedge clk);
            chk("R6 irq not yet", {31'b0, irq}, 32'd0);
            expect_read("R5 single select", SEL_A, 32'h40 | 32'(i));
            chk("R6 irq high", {31'b0, irq}, 32'd1);
            bus_write(12'(i * 4), 32'h0);
            chk("R6 irq still high at mask edge", {31'b0, irq}, 32'd1);
            @(negedge clk);
            chk("R6 irq low after mask", {31'b0, irq}, 32'd0);
            expect_read("R4 masked select", SEL_A, 32'h0);
            src = '0;
        end

        // R3: near-miss codes do not enable
        src = '1;
        bus_write(12'd40, 32'h50);
        @(negedge clk);
        expect_read("R3 code 0x50", SEL_A, 32'h0);
        bus_write(12'd40, 32'h7F);
        expect_read("R3 code 0x7F", SEL_A, 32'h0);
        bus_write(12'd40, 32'h01);
        expect_read("R3 code 0x01", SEL_A, 32'h0);
        bus_write(12'd40, 32'h11);
        expect_read("R3 code 0x11", SEL_A, 32'h0);
        chk("R3 irq stays low", {31'b0, irq}, 32'd0);
        bus_write(12'd40, 32'(ENC));
        expect_read("R3 exact code", SEL_A, 32'h4A);

        // R5: multi-source priority patterns, all enabled
        for (int i = 0; i < 64; i++) bus_write(12'(i * 4), 32'(ENC));
        for (int k = 0; k < 64; k++) begin
            p = (64'h8000_0000_0000_0000 >> (k % 7)) | (64'h1 << k) | (64'h1 << ((k * 13) % 64));
            src = p;
            @(negedge clk);
            expect_read("R5 lowest wins", SEL_A, lowest_word(p));
        end

        // R5: masking the winner promotes the next one
        src = (64'h1 << 3) | (64'h1 << 20) | (64'h1 << 61);
        bus_write(12'd12, 32'h0);
        expect_read("R5 next after mask", SEL_A, 32'h54);
        bus_write(12'd80, 32'h0);
        expect_read("R5 top remaining", SEL_A, 32'h7D);

        // R7: level drop, no latching
        src = 64'h1 << 61;
        @(negedge clk);
        @(negedge clk);
        chk("R7 irq high", {31'b0, irq}, 32'd1);
        src = '0;
        @(negedge clk);
        chk("R7 irq one clock after drop", {31'b0, irq}, 32'd1);
        expect_read("R7 select cleared", SEL_A, 32'h0);
        chk("R7 irq low", {31'b0, irq}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule